// File: doc/BRIEF.md
# Compressed Test Mode Memory Model

This block is a synthesizable behavioural model of a four-bit-wide dynamic memory core whose storage is built as byte-wide words, each holding twice as many bits as one access moves. Strobe cycles reach it already classified, as a one-hot event vector: read access, write access, write-enable-low CAS-before-RAS (test entry), and the three refresh kinds that leave test mode (CAS-before-RAS, RAS-only and hidden). Timing, electrical levels and real refresh are not modelled.

In normal mode the lowest address bit picks one nibble of the addressed byte for each read and write. In compressed test mode a write fills all eight bits of the addressed byte with one input bit. A read reports a single pass flag that is set when all eight bits agree. Test time for a pattern that repeats per byte therefore drops by half. The mode change takes effect on the clock edge that samples the event. Read data appears one clock after the read event.

Top module: `cmp_tm_dram`

## Requirements
- R1: After reset, test_mode is 0, rd_valid is 0, rd_data is 0 and every stored byte is 0.
- R2: A normal-mode write (evt bit 1) stores wdata in the low nibble of byte addr[ADDR_W-1:1] when addr[0] is 0, or in the high nibble when addr[0] is 1. The other nibble keeps its value.
- R3: A read event (evt bit 0) makes rd_valid 1 for exactly the following cycle. In normal mode rd_data then holds the nibble selected as in R2.
- R4: An entry event (evt bit 2) sets test_mode from the next cycle on.
- R5: Each of the exit events clears test_mode from the next cycle on: CAS-before-RAS refresh (evt bit 3), RAS-only refresh (evt bit 4) and hidden refresh (evt bit 5).
- R6: A test-mode write sets all eight bits of the addressed byte to wdata[0]. wdata[3:1] has no effect.
- R7: A test-mode read returns rd_data[0] = 1 when the eight bits of the byte are all equal and 0 otherwise, with rd_data[3:1] always 1.
- R8: In test mode addr[0] is ignored for both reads and writes.
- R9: Mode events leave the stored contents unchanged, so data survives entry into test mode and exit from it.
- R10: An evt value with more than one bit set has no effect on the mode, the storage or rd_valid.
- R11: rd_data holds its value in every cycle in which rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 6 | One-hot cycle event: 0 read, 1 write, 2 test entry, 3 CBR refresh, 4 RAS-only refresh, 5 hidden refresh |
| addr | input | ADDR_W | Byte index in the upper bits, nibble select in bit 0 |
| wdata | input | 4 | Write data |
| rd_data | output | 4 | Read result, nibble or compressed flag |
| rd_valid | output | 1 | One-cycle pulse marking new read data |
| test_mode | output | 1 | 1 while compressed test mode is active |

## Verification
The case that is hardest to reach from the ports is a compressed read that fails. The only way to make the eight bits of a byte disagree is to write its two nibbles with different values in normal mode first, because a test-mode write always makes them agree. The stimulus therefore writes unequal nibbles and then enters test mode. It reads the byte with both values of the nibble-select bit, rejects a multi-bit event while still in test mode, and then leaves through each of the three exit kinds in turn. Normal reads after leaving show that the stored nibbles survived every mode change.

// File: rtl/cmp_tm_pkg.sv
package cmp_tm_pkg;

    localparam int EVT_W      = 6;
    localparam int EV_READ    = 0;
    localparam int EV_WRITE   = 1;
    localparam int EV_ENTER   = 2;
    localparam int EV_CBR     = 3;
    localparam int EV_RASONLY = 4;
    localparam int EV_HIDDEN  = 5;
    localparam int NIB_W      = 4;
    localparam int BYTE_W     = 2 * NIB_W;

    typedef struct packed {
        logic rd;
        logic wr;
        logic enter;
        logic leave;
    } cmd_t;

endpackage

// File: rtl/cmp_tm_evt_decode.sv
module cmp_tm_evt_decode
    import cmp_tm_pkg::*;
(
    input  logic [EVT_W-1:0] evt,
    output cmd_t             cmd
);

    logic legal;

    always_comb begin
        legal      = (evt != '0) && ((evt & (evt - 1'b1)) == '0);
        cmd.rd     = legal && evt[EV_READ];
        cmd.wr     = legal && evt[EV_WRITE];
        cmd.enter  = legal && evt[EV_ENTER];
        cmd.leave  = legal && (evt[EV_CBR] || evt[EV_RASONLY] || evt[EV_HIDDEN]);
    end

endmodule

// File: rtl/cmp_tm_mode_ctl.sv
module cmp_tm_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic leave,
    output logic tm
);

    typedef struct packed {
        logic tm;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enter) begin
            st_d.tm = 1'b1;
        end else if (leave) begin
            st_d.tm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tm = st_q.tm;

endmodule

// File: rtl/cmp_tm_array.sv
module cmp_tm_array
    import cmp_tm_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              tm,
    input  logic [IDX_W-1:0]  idx,
    input  logic              half,
    input  logic [NIB_W-1:0]  wdata,
    output logic [BYTE_W-1:0] rd_word
);

    logic [BYTE_W-1:0] mem_q [WORDS];
    logic [BYTE_W-1:0] word_d;

    always_comb begin
        rd_word = mem_q[idx];
        if (tm) begin
            word_d = {BYTE_W{wdata[0]}};
        end else if (half) begin
            word_d = {wdata, rd_word[NIB_W-1:0]};
        end else begin
            word_d = {rd_word[BYTE_W-1:NIB_W], wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[idx] <= word_d;
        end
    end

endmodule

// File: rtl/cmp_tm_rd_fmt.sv
module cmp_tm_rd_fmt
    import cmp_tm_pkg::*;
(
    input  logic [BYTE_W-1:0] word,
    input  logic              half,
    input  logic              tm,
    output logic [NIB_W-1:0]  nib
);

    logic agree;

    always_comb begin
        agree = (&word) || (~|word);
        if (tm) begin
            nib = {{(NIB_W-1){1'b1}}, agree};
        end else if (half) begin
            nib = word[BYTE_W-1:NIB_W];
        end else begin
            nib = word[NIB_W-1:0];
        end
    end

endmodule

// File: rtl/cmp_tm_dram.sv
module cmp_tm_dram
    import cmp_tm_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int ADDR_W = $clog2(WORDS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]  wdata,
    output logic [NIB_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              test_mode
);

    localparam int IDX_W = ADDR_W - 1;

    typedef struct packed {
        logic             vld;
        logic [NIB_W-1:0] data;
    } out_st_t;

    cmd_t              cmd;
    logic              tm;
    logic [BYTE_W-1:0] word;
    logic [NIB_W-1:0]  nib;
    logic              half;
    out_st_t           out_d, out_q;

    assign half = addr[0];

    cmp_tm_evt_decode u_dec (
        .evt (evt),
        .cmd (cmd)
    );

    cmp_tm_mode_ctl u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .enter (cmd.enter),
        .leave (cmd.leave),
        .tm    (tm)
    );

    cmp_tm_array #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cmd.wr),
        .tm      (tm),
        .idx     (addr[ADDR_W-1:1]),
        .half    (half),
        .wdata   (wdata),
        .rd_word (word)
    );

    cmp_tm_rd_fmt u_fmt (
        .word (word),
        .half (half),
        .tm   (tm),
        .nib  (nib)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = cmd.rd;
        if (cmd.rd) begin
            out_d.data = nib;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data   = out_q.data;
    assign rd_valid  = out_q.vld;
    assign test_mode = tm;

endmodule

// File: rtl/cmp_tm_chk.sv
module cmp_tm_chk
    import cmp_tm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [EVT_W-1:0] evt,
    input logic [NIB_W-1:0] rd_data,
    input logic             rd_valid,
    input logic             test_mode
);

    // R4
    enter_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == (EVT_W'(1) << EV_ENTER)) |=> test_mode);

    // R5
    exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt == (EVT_W'(1) << EV_CBR)) || (evt == (EVT_W'(1) << EV_RASONLY)) ||
         (evt == (EVT_W'(1) << EV_HIDDEN))) |=> !test_mode);

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == (EVT_W'(1) << EV_READ)) |=> rd_valid);

    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != (EVT_W'(1) << EV_READ)) |=> !rd_valid);

    // R10
    multi_evt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(evt) > 1) |=> $stable(test_mode));

    // R7
    tm_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == (EVT_W'(1) << EV_READ)) && test_mode |=> (rd_data[3:1] == 3'b111));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

endmodule

bind cmp_tm_dram cmp_tm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .test_mode (test_mode)
);

// File: tb/tb_cmp_tm_dram.sv
module tb_cmp_tm_dram;

    localparam int WORDS  = 64;
    localparam int ADDR_W = $clog2(WORDS) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [5:0]        evt = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0]        wdata = '0;
    logic [3:0]        rd_data;
    logic              rd_valid;
    logic              test_mode;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_mem [WORDS];
    logic       tb_tm = 1'b0;
    logic [3:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    cmp_tm_dram #(.WORDS(WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .test_mode(test_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R10 unexpected rd_valid", 1, 0);
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic drive(input logic [5:0] e, input int a, input logic [3:0] d);
        @(negedge clk);
        evt = e;
        addr = a[ADDR_W-1:0];
        wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        evt = '0;
    endtask

    task automatic wr(input int a, input logic [3:0] d);
        drive(6'b000010, a, d);
        if (tb_tm) exp_mem[a >> 1] = {8{d[0]}};
        else if (a & 1) exp_mem[a >> 1][7:4] = d;
        else exp_mem[a >> 1][3:0] = d;
    endtask

    task automatic rd(input int a, input string t);
        logic [7:0] w;
        w = exp_mem[a >> 1];
        drive(6'b000001, a, 4'h0);
        if (tb_tm) exp_q.push_back({3'b111, (w == 8'h00) || (w == 8'hFF)});
        else exp_q.push_back((a & 1) ? w[7:4] : w[3:0]);
        tag_q.push_back(t);
    endtask

    task automatic mode_evt(input logic [5:0] e, input logic nt, input string t);
        drive(e, 0, 4'h0);
        tb_tm = nt;
        idle();
        check(test_mode == nt, t, test_mode, nt);
    endtask

    initial begin
        #800000;
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(test_mode == 1'b0, "R1 test_mode", test_mode, 0);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        check(rd_data == 4'h0, "R1 rd_data", rd_data, 0);
        rd(9, "R1 stored zero");
        // R2 R3 nibble writes and reads
        wr(6, 4'hA);
        wr(7, 4'h5);
        rd(6, "R3 low nibble");
        rd(7, "R3 high nibble");
        wr(6, 4'h3);
        rd(7, "R2 other nibble kept");
        rd(6, "R2 low nibble new");
        for (int i = 0; i < 8; i++) wr(16 + i, 4'(i * 3 + 1));
        for (int i = 0; i < 8; i++) rd(16 + i, "R2 pattern");
        idle();
        // R11 hold when no read
        begin
            logic [3:0] last;
            last = rd_data;
            idle();
            idle();
            check(rd_data == last && !rd_valid, "R11 hold", rd_data, last);
        end
        // R4 entry
        mode_evt(6'b000100, 1'b1, "R4 enter");
        rd(6, "R7 mismatch flag");
        rd(7, "R8 half ignored on read");
        wr(11, 4'b1110);
        rd(10, "R6 replicate zero");
        wr(12, 4'b0001);
        rd(13, "R6 replicate one, R8");
        rd(9, "R7 pass on zero byte");
        idle();
        // R10 illegal events
        drive(6'b001100, 0, 4'h0);
        idle();
        check(test_mode == 1'b1, "R10 mode kept", test_mode, 1);
        drive(6'b000011, 12, 4'h0);
        idle();
        check(rd_valid == 1'b0, "R10 no read", rd_valid, 0);
        // R5 exits, R9 preservation
        mode_evt(6'b001000, 1'b0, "R5 CBR exit");
        rd(12, "R10 R9 byte 6 low");
        rd(13, "R9 byte 6 high");
        rd(10, "R9 byte 5 low");
        rd(6, "R9 byte 3 low");
        rd(7, "R9 byte 3 high");
        idle();
        mode_evt(6'b000100, 1'b1, "R4 reenter");
        mode_evt(6'b010000, 1'b0, "R5 RAS-only exit");
        mode_evt(6'b000100, 1'b1, "R4 reenter 2");
        mode_evt(6'b100000, 1'b0, "R5 hidden exit");
        rd(20, "R9 after exits");
        idle();
        idle();
        check(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule